// File: doc/BRIEF.md
# Dual-Compare Pulse Generator

This block is an output-compare channel with its own timer. A free-running up-counter runs from zero up to a programmable period and then wraps. Two compare values are checked against that one counter: a match on the first drives the output pin high, and a match on the second drives it low. Firing either one pulse per arming or a pulse in every timer cycle yields edges placed anywhere inside the period. A third mode turns the channel into a plain PWM source, in which the falling-edge value acts as the duty count measured from the start of each period.

Software-style settings arrive on plain inputs and are captured into a staging copy whenever the update strobe is high. The staging copy becomes the working copy only at a period match, or at once while the channel is stopped. A pulse that is already under way is therefore never cut short by a change of settings. The block reports each period match as a one-cycle interrupt pulse. It also raises a one-cycle flag whenever the counter equals either compare value.

Top module: `pulse_gen`

## Requirements
- R1: While `en_i` is high, the counter steps 0, 1, ... up to the working period value P and then returns to 0, so one timer cycle lasts P+1 clocks. While `en_i` is low, the counter is cleared and held at 0. After reset, `pulse_o`, `period_irq_o` and `cmp_evt_o` are all 0.
- R2: `period_irq_o` is high for exactly the one cycle that follows a clock edge at which `en_i` was high and the counter equalled P.
- R3: In modes 0 (single) and 1 (continuous), `pulse_o` goes high at the edge where the counter equals the working rising value, provided the two compare values differ.
- R4: In modes 0 and 1, `pulse_o` goes low at the edge where the counter equals the working falling value, provided the two compare values differ.
- R5: In mode 2 (PWM), `pulse_o` is high in the cycle after each edge at which the counter value c satisfies c < D, where D is the falling value. This gives D high cycles in every P+1.
- R6: In mode 0, the channel disarms at its falling-edge match and produces no further rising edge until `load_i` is strobed. That strobe re-arms the channel. Reset leaves the channel armed.
- R7: In mode 1, the rising and falling edges repeat in every timer cycle.
- R8: An edge with `load_i` high captures `period_i`, `cmp_rise_i`, `cmp_fall_i` and `mode_i` into staging. The staging copy is moved into the working copy at an edge where `en_i` is high and the counter equals P, or at any edge while `en_i` is low. A capture and a transfer at the same edge move the older staging contents.
- R9: In modes 0 and 1, if the working rising and falling values are equal, `pulse_o` keeps its level and no edge is produced.
- R10: A compare value greater than P never matches. `pulse_o` keeps whatever level it had.
- R11: `cmp_evt_o` is high for the one cycle after an edge at which `en_i` was high and the counter equalled either working compare value, in every mode.
- R12: `en_i` low forces `pulse_o` to 0 at the next edge. Mode 3 holds `pulse_o` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Timer and channel enable |
| period_i | input | W | Period value P (counter wraps after P) |
| cmp_rise_i | input | W | Compare value for the rising edge |
| cmp_fall_i | input | W | Compare value for the falling edge, also the PWM duty |
| mode_i | input | 2 | 0 single, 1 continuous, 2 PWM, 3 hold low |
| load_i | input | 1 | Capture settings into staging, re-arm single mode |
| pulse_o | output | 1 | Pulse output pin |
| period_irq_o | output | 1 | One-cycle period-match interrupt |
| cmp_evt_o | output | 1 | One-cycle compare-match flag |

## Verification
Every output is a single register behind the counter compare. So `pulse_o`, `period_irq_o` and `cmp_evt_o` all change at the edge that follows the edge where the counter held the matching value. New settings need one edge to reach staging and then wait for a period match, or a stopped edge, before they act. The bench samples on the falling clock edge and compares every output each cycle against a behavioural model that applies this one-edge delay. Directed windows of whole timer cycles also count rising edges, high cycles, interrupts and flags against hand-computed totals. Interrupt spacing is measured across a mid-period settings change to confirm the deferred update.

// File: rtl/pg_pkg.sv
package pg_pkg;
  typedef enum logic [1:0] {
    PG_SINGLE = 2'd0,
    PG_CONT   = 2'd1,
    PG_PWM    = 2'd2,
    PG_HOLD   = 2'd3
  } pg_mode_e;

  localparam int unsigned PG_NUM_FIELDS = 3;
  localparam int unsigned PG_F_PERIOD   = 0;
  localparam int unsigned PG_F_RISE     = 1;
  localparam int unsigned PG_F_FALL     = 2;
endpackage

// File: rtl/pg_timer.sv
module pg_timer #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic [W-1:0] period_i,
  output logic [W-1:0] cnt_o,
  output logic         wrap_o
);
  logic [W-1:0] cnt_q;

  assign wrap_o = en_i && (cnt_q == period_i);
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (!en_i)   cnt_q <= '0;
    else if (wrap_o)  cnt_q <= '0;
    else              cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/pg_shadow.sv
module pg_shadow
  import pg_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic         upd_i,
  input  logic [W-1:0] period_i,
  input  logic [W-1:0] rise_i,
  input  logic [W-1:0] fall_i,
  input  logic [1:0]   mode_i,
  output logic [W-1:0] period_o,
  output logic [W-1:0] rise_o,
  output logic [W-1:0] fall_o,
  output pg_mode_e     mode_o
);
  logic [W-1:0] fld_in  [PG_NUM_FIELDS];
  logic [W-1:0] fld_act [PG_NUM_FIELDS];
  pg_mode_e     mode_stg_q, mode_act_q;

  assign fld_in[PG_F_PERIOD] = period_i;
  assign fld_in[PG_F_RISE]   = rise_i;
  assign fld_in[PG_F_FALL]   = fall_i;

  for (genvar g = 0; g < PG_NUM_FIELDS; g++) begin : g_fld
    logic [W-1:0] stg_q, act_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        stg_q <= '0;
        act_q <= '0;
      end else begin
        if (load_i) stg_q <= fld_in[g];
        if (upd_i)  act_q <= stg_q;
      end
    end
    assign fld_act[g] = act_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_stg_q <= PG_SINGLE;
      mode_act_q <= PG_SINGLE;
    end else begin
      if (load_i) mode_stg_q <= pg_mode_e'(mode_i);
      if (upd_i)  mode_act_q <= mode_stg_q;
    end
  end

  assign period_o = fld_act[PG_F_PERIOD];
  assign rise_o   = fld_act[PG_F_RISE];
  assign fall_o   = fld_act[PG_F_FALL];
  assign mode_o   = mode_act_q;
endmodule

// File: rtl/pg_edge.sv
module pg_edge
  import pg_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic         arm_i,
  input  logic [W-1:0] cnt_i,
  input  logic [W-1:0] rise_i,
  input  logic [W-1:0] fall_i,
  input  pg_mode_e     mode_i,
  output logic         pin_o,
  output logic         evt_o
);
  logic pin_q, evt_q, armed_q;
  logic rise_eq, fall_eq, distinct, rise_hit, fall_hit, gate;

  assign rise_eq  = (cnt_i == rise_i);
  assign fall_eq  = (cnt_i == fall_i);
  assign distinct = (rise_i != fall_i);
  assign rise_hit = rise_eq && distinct;
  assign fall_hit = fall_eq && distinct;
  assign gate     = (mode_i == PG_CONT) || armed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pin_q   <= 1'b0;
      evt_q   <= 1'b0;
      armed_q <= 1'b1;
    end else begin
      evt_q <= en_i && (rise_eq || fall_eq);
      if (arm_i)
        armed_q <= 1'b1;
      else if (en_i && mode_i == PG_SINGLE && armed_q && fall_hit)
        armed_q <= 1'b0;
      if (!en_i) begin
        pin_q <= 1'b0;
      end else begin
        unique case (mode_i)
          PG_PWM:  pin_q <= (cnt_i < fall_i);
          PG_HOLD: pin_q <= 1'b0;
          default: begin
            if (gate && fall_hit)      pin_q <= 1'b0;
            else if (gate && rise_hit) pin_q <= 1'b1;
          end
        endcase
      end
    end
  end

  assign pin_o = pin_q;
  assign evt_o = evt_q;
endmodule

// File: rtl/pulse_gen.sv
module pulse_gen
  import pg_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic [W-1:0] period_i,
  input  logic [W-1:0] cmp_rise_i,
  input  logic [W-1:0] cmp_fall_i,
  input  logic [1:0]   mode_i,
  input  logic         load_i,
  output logic         pulse_o,
  output logic         period_irq_o,
  output logic         cmp_evt_o
);
  logic [W-1:0] cnt, per_a, rise_a, fall_a;
  pg_mode_e     mode_a;
  logic         wrap, upd, irq_q;

  assign upd = !en_i || wrap;

  pg_timer #(.W(W)) u_timer (
    .clk_i, .rst_ni, .en_i,
    .period_i (per_a),
    .cnt_o    (cnt),
    .wrap_o   (wrap)
  );

  pg_shadow #(.W(W)) u_shadow (
    .clk_i, .rst_ni, .load_i,
    .upd_i    (upd),
    .period_i (period_i),
    .rise_i   (cmp_rise_i),
    .fall_i   (cmp_fall_i),
    .mode_i   (mode_i),
    .period_o (per_a),
    .rise_o   (rise_a),
    .fall_o   (fall_a),
    .mode_o   (mode_a)
  );

  pg_edge #(.W(W)) u_edge (
    .clk_i, .rst_ni, .en_i,
    .arm_i  (load_i),
    .cnt_i  (cnt),
    .rise_i (rise_a),
    .fall_i (fall_a),
    .mode_i (mode_a),
    .pin_o  (pulse_o),
    .evt_o  (cmp_evt_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= wrap;
  end

  assign period_irq_o = irq_q;
endmodule

// File: rtl/pg_checker.sv
module pg_checker #(
  parameter int unsigned W = 16
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         en_i,
  input logic [W-1:0] cnt,
  input logic [W-1:0] per_a,
  input logic [W-1:0] rise_a,
  input logic [W-1:0] fall_a,
  input logic [1:0]   mode_a,
  input logic         pulse_o,
  input logic         period_irq_o
);
  AST_CNT_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt <= per_a); // R1

  AST_IRQ_FROM_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    period_irq_o |-> ($past(en_i) && $past(cnt) == $past(per_a))); // R2

  AST_RISE_ON_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(pulse_o) && $past(mode_a) != 2'd2) |-> ($past(cnt) == $past(rise_a))); // R3

  AST_FALL_ON_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(pulse_o) && $past(en_i) && $past(mode_a) inside {2'd0, 2'd1})
      |-> ($past(cnt) == $past(fall_a))); // R4

  AST_PWM_LEVEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(en_i) && $past(mode_a) == 2'd2) |-> (pulse_o == ($past(cnt) < $past(fall_a)))); // R5

  AST_ACTIVE_AT_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(per_a) |-> (!$past(en_i) || $past(cnt) == $past(per_a))); // R8

  AST_NO_EDGE_EQUAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(en_i) && $past(mode_a) inside {2'd0, 2'd1} && $past(rise_a) == $past(fall_a))
      |-> $stable(pulse_o)); // R9

  AST_STOP_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(en_i) |-> (!pulse_o && cnt == '0)); // R12
endmodule

bind pulse_gen pg_checker #(.W(W)) u_pg_checker (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .en_i         (en_i),
  .cnt          (cnt),
  .per_a        (per_a),
  .rise_a       (rise_a),
  .fall_a       (fall_a),
  .mode_a       (mode_a),
  .pulse_o      (pulse_o),
  .period_irq_o (period_irq_o)
);

// File: tb/tb_pulse_gen.sv
module tb_pulse_gen;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         en = 1'b0;
  logic [W-1:0] per = '0, rise = '0, fall = '0;
  logic [1:0]   mode = 2'd0;
  logic         load = 1'b0;
  logic         pin, irq, evt;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  pulse_gen #(.W(W)) dut (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en),
    .period_i(per), .cmp_rise_i(rise), .cmp_fall_i(fall),
    .mode_i(mode), .load_i(load),
    .pulse_o(pin), .period_irq_o(irq), .cmp_evt_o(evt)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference
  int m_cnt, m_per, m_rise, m_fall, m_mode;
  int s_per, s_rise, s_fall, s_mode;
  bit m_armed, m_pin, m_irq, m_evt;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_per = 0; m_rise = 0; m_fall = 0; m_mode = 0;
      s_per = 0; s_rise = 0; s_fall = 0; s_mode = 0;
      m_armed = 1; m_pin = 0; m_irq = 0; m_evt = 0;
    end else begin
      bit hit_p, rh, fh, go, dis;
      hit_p = en && (m_cnt == m_per);
      m_irq = hit_p;
      m_evt = en && (m_cnt == m_rise || m_cnt == m_fall);
      rh = (m_cnt == m_rise) && (m_rise != m_fall);
      fh = (m_cnt == m_fall) && (m_rise != m_fall);
      go = (m_mode == 1) || m_armed;
      dis = en && m_mode == 0 && m_armed && fh;
      if (!en) m_pin = 0;
      else if (m_mode == 2) m_pin = (m_cnt < m_fall);
      else if (m_mode == 3) m_pin = 0;
      else if (go && fh) m_pin = 0;
      else if (go && rh) m_pin = 1;
      if (load) m_armed = 1; else if (dis) m_armed = 0;
      m_cnt = (!en || hit_p) ? 0 : m_cnt + 1;
      if (!en || hit_p) begin
        m_per = s_per; m_rise = s_rise; m_fall = s_fall; m_mode = s_mode;
      end
      if (load) begin
        s_per = per; s_rise = rise; s_fall = fall; s_mode = mode;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(pin == m_pin, "R3/R4 pulse_o vs model", pin, m_pin);
      chk(irq == m_irq, "R2 period_irq_o vs model", irq, m_irq);
      chk(evt == m_evt, "R11 cmp_evt_o vs model", evt, m_evt);
    end
  end

  int n_rise, n_high, n_irq, n_evt;
  bit last_pin;

  task automatic run(input int n);
    n_rise = 0; n_high = 0; n_irq = 0; n_evt = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (pin && !last_pin) n_rise++;
      if (pin) n_high++;
      if (irq) n_irq++;
      if (evt) n_evt++;
      last_pin = pin;
    end
  endtask

  task automatic setup(input int p, input int r, input int f, input int m);
    @(negedge clk);
    en = 0; per = W'(p); rise = W'(r); fall = W'(f); mode = 2'(m); load = 1;
    @(negedge clk);
    load = 0;
    @(negedge clk);
    @(negedge clk);
    last_pin = pin;
    en = 1;
  endtask

  task automatic gap_to_irq(output int g, input int load_at, input int p, input int r, input int f);
    g = 0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      load = 0;
      g++;
      if (irq) break;
      if (i == load_at) begin
        per = W'(p); rise = W'(r); fall = W'(f); load = 1;
      end
    end
  endtask

  initial begin
    fork
      begin
        repeat (100000) @(negedge clk);
        chk(0, "watchdog", 0, 1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    join_none

    repeat (3) @(negedge clk);
    chk(pin == 0 && irq == 0 && evt == 0, "R1 reset outputs", {pin, irq, evt}, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    chk(pin == 0 && irq == 0, "R1 idle after reset", {pin, irq}, 0);

    // continuous: P=9 rise 2 fall 6
    setup(9, 2, 6, 1);
    run(30);
    chk(n_irq == 3, "R1 wrap every P+1 / R2", n_irq, 3);
    chk(n_rise == 3, "R7 one rise per timer cycle", n_rise, 3);
    chk(n_high == 12, "R3 R4 high width", n_high, 12);
    chk(n_evt == 6, "R11 compare flags", n_evt, 6);

    // deferred update: new period takes effect only at a match
    begin
      int g1, g2;
      gap_to_irq(g1, 200, 0, 0, 0);
      gap_to_irq(g1, 2, 4, 1, 3);
      gap_to_irq(g2, 200, 0, 0, 0);
      chk(g1 == 10, "R8 old period until match", g1, 10);
      chk(g2 == 5, "R8 new period after match", g2, 5);
    end

    // single pulse
    setup(9, 2, 5, 0);
    run(40);
    chk(n_rise == 1, "R6 single pulse once", n_rise, 1);
    chk(n_high == 3, "R6 single pulse width", n_high, 3);
    @(negedge clk); load = 1;
    @(negedge clk); load = 0;
    run(20);
    chk(n_rise == 1, "R6 re-armed by load", n_rise, 1);

    // equal compare values
    setup(9, 4, 4, 1);
    run(30);
    chk(n_high == 0, "R9 no pulse when equal", n_high, 0);
    chk(n_evt == 3, "R11 flag still raised when equal", n_evt, 3);

    // compare beyond period
    setup(9, 3, 20, 1);
    run(30);
    chk(n_rise == 1, "R10 rise once, fall never matches", n_rise, 1);
    chk(pin == 1, "R10 level kept", pin, 1);
    chk(n_evt == 3, "R10 out-of-range value never flags", n_evt, 3);
    @(negedge clk); en = 0;
    @(negedge clk);
    chk(pin == 0, "R12 disable forces low", pin, 0);

    // PWM duty 3 of 10
    setup(9, 0, 3, 2);
    run(30);
    chk(n_high == 9, "R5 pwm duty cycles", n_high, 9);
    chk(n_rise == 3, "R5 pwm one pulse per cycle", n_rise, 3);

    // hold mode
    setup(9, 2, 6, 3);
    run(30);
    chk(n_high == 0, "R12 hold mode low", n_high, 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule